// File: doc/BRIEF.md
# Cell Balancing Phase Sequencer

This block decides which cell shunts of a series lithium stack of up to ten cells are switched on. Each clock it takes one millivolt code per cell, the number of cells fitted, and two nine-step selector indices: one picks the overvoltage level and one picks an offset below it. From these it forms a balance voltage, which is the overvoltage level minus the offset, with a floor of 3750 mV. A zero offset index turns balancing off.

Once balancing is allowed, the block runs a fixed cycle of four windows: measure, shunt even-numbered cells, measure, shunt odd-numbered cells. The cycle then repeats. A measurement flag tells the converter when the shunts are quiet. Cell readings are judged once, on the last clock of each measurement window, and that judgement holds for the whole balancing window that follows. A configuration bit chooses what allows balancing: a charger-detect comparator or a sleep pin.

Top module: `cell_bal_seq`

## Requirements
- R1: The balance voltage is max(4100 + 50·ov − 50·off, 3750) mV. Here ov and off are the overvoltage and offset indices, and any index above 8 counts as 8. A cell counts as above the balance voltage only when its code is strictly greater than it.
- R2: Balancing is allowed when the offset index is non-zero and the chosen source is high. The source is `chg_det` when `src_sleep` is 0 and `sleep_pin` when it is 1. When balancing is not allowed, `shunt_en` is all zero and `meas_win` is low from the next clock on.
- R3: One time unit is `UNIT_CLKS` clocks. The clock after balancing becomes allowed starts a 5-unit measurement window. This is followed by a 123-unit even window, a 5-unit measurement window and a 123-unit odd window, and the cycle repeats. `meas_win` is high exactly during the measurement windows.
- R4: Every shunt enable is zero while `meas_win` is high.
- R5: In the even window only cells 2, 4, 6, 8 and 10 (bits 1, 3, 5, 7, 9) may be shunted. In the odd window only cells 1, 3, 5, 7 and 9 (bits 0, 2, 4, 6, 8) may be shunted.
- R6: Within the active parity, a cell is shunted when its latched reading was above the balance voltage.
- R7: If every fitted cell was latched above the balance voltage, no cell is shunted in that window.
- R8: Cell k (bit k−1) is fitted only when k ≤ `cell_cnt`. A cell that is not fitted is never shunted and is left out of R7.
- R9: Readings are taken on the last clock of each measurement window and held through the next balancing window. Later input changes have no effect until the next measurement.
- R10: Disabling balancing during any window sends the schedule back to the start of the first measurement window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cell_mv | input | NCELL*VW | Cell k reading in mV at bits [(k−1)·VW +: VW] |
| cell_cnt | input | $clog2(NCELL+1) | Number of fitted cells |
| ov_sel | input | 4 | Overvoltage level index, 0..8 |
| ofs_sel | input | 4 | Balance offset index, 0..8; 0 disables |
| src_sleep | input | 1 | Enable source select: 0 charger detect, 1 sleep pin |
| chg_det | input | 1 | Charger-detect comparator output |
| sleep_pin | input | 1 | Sleep pin level |
| shunt_en | output | NCELL | Per-cell shunt enable, bit k−1 for cell k |
| meas_win | output | 1 | High during measurement windows |

## Verification
Two things can happen on the same clock: the last edge of a measurement window latches new cell judgements, and the inputs change. The bench changes the cell readings in the middle of an even window. It then requires the shunts to keep following the earlier judgement until the next measurement edge, and the following odd window to follow the new readings. The same clock is also shared by a window boundary and a drop of the enable. The bench removes the enable inside a balancing window and requires the shunts to be quiet one clock later and the schedule to restart with a measurement window. Every selector pair is swept, including the floor case, and each sample point is predicted from the window lengths.

// File: rtl/cell_bal_seq.sv
module cell_bal_seq #(
  parameter int NCELL      = 10,
  parameter int VW         = 13,
  parameter int UNIT_CLKS  = 64,
  parameter int MEAS_UNITS = 5,
  parameter int BAL_UNITS  = 123,
  parameter int OV_BASE_MV = 4100,
  parameter int STEP_MV    = 50,
  parameter int FLOOR_MV   = 3750,
  parameter int SEL_MAX    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NCELL*VW-1:0]          cell_mv,
  input  logic [$clog2(NCELL+1)-1:0]   cell_cnt,
  input  logic [3:0]                   ov_sel,
  input  logic [3:0]                   ofs_sel,
  input  logic                         src_sleep,
  input  logic                         chg_det,
  input  logic                         sleep_pin,
  output logic [NCELL-1:0]             shunt_en,
  output logic                         meas_win
);
  localparam int CW = $clog2(NCELL+1);
  localparam int PW = (UNIT_CLKS > 1) ? $clog2(UNIT_CLKS) : 1;
  localparam int UW = $clog2(BAL_UNITS + 1);

  typedef enum logic [1:0] {PH_MEAS_A, PH_EVEN, PH_MEAS_B, PH_ODD} phase_t;

  phase_t          phase;
  logic            act;
  logic [PW-1:0]   pre;
  logic [UW-1:0]   unit;
  logic [NCELL-1:0] over, above, in_use, even_m, odd_m;
  logic [VW-1:0]   vbal;
  logic            bal_en, is_meas, unit_last, tick, all_over;

  always_comb begin
    int ov_i, of_i, raw;
    ov_i = (int'(ov_sel)  > SEL_MAX) ? SEL_MAX : int'(ov_sel);
    of_i = (int'(ofs_sel) > SEL_MAX) ? SEL_MAX : int'(ofs_sel);
    raw  = OV_BASE_MV + STEP_MV * ov_i - STEP_MV * of_i;
    vbal = (raw < FLOOR_MV) ? VW'(FLOOR_MV) : VW'(raw);
  end

  assign bal_en    = (ofs_sel != 4'd0) && (src_sleep ? sleep_pin : chg_det);
  assign is_meas   = (phase == PH_MEAS_A) || (phase == PH_MEAS_B);
  assign tick      = (pre == PW'(UNIT_CLKS - 1));
  assign unit_last = (unit == (is_meas ? UW'(MEAS_UNITS - 1) : UW'(BAL_UNITS - 1)));

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    assign above[i]  = cell_mv[i*VW +: VW] > vbal;
    assign in_use[i] = CW'(i + 1) <= cell_cnt;
    assign even_m[i] = (i % 2) == 1;
    assign odd_m[i]  = (i % 2) == 0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      phase <= PH_MEAS_A;
      pre   <= '0;
      unit  <= '0;
      over  <= '0;
    end else if (!bal_en) begin
      act   <= 1'b0;
      phase <= PH_MEAS_A;
      pre   <= '0;
      unit  <= '0;
    end else begin
      act <= 1'b1;
      if (act) begin
        if (tick) begin
          pre <= '0;
          if (unit_last) begin
            unit  <= '0;
            phase <= phase_t'(phase + 2'd1);
            if (is_meas) over <= above;
          end else begin
            unit <= unit + UW'(1);
          end
        end else begin
          pre <= pre + PW'(1);
        end
      end
    end
  end

  assign all_over = &(over | ~in_use);
  assign meas_win = act & is_meas;
  assign shunt_en = (act && !is_meas && !all_over)
                    ? (over & in_use & ((phase == PH_EVEN) ? even_m : odd_m))
                    : '0;
endmodule

// File: rtl/cell_bal_seq_chk.sv
module cell_bal_seq_chk #(
  parameter int NCELL = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [$clog2(NCELL+1)-1:0] cell_cnt,
  input logic [3:0]                 ofs_sel,
  input logic                       src_sleep,
  input logic                       chg_det,
  input logic                       sleep_pin,
  input logic [NCELL-1:0]           shunt_en,
  input logic                       meas_win
);
  localparam int CW = $clog2(NCELL+1);
  logic en;
  logic [NCELL-1:0] unfit, ev_m, od_m;
  assign en = (ofs_sel != 4'd0) && (src_sleep ? sleep_pin : chg_det);
  always_comb begin
    for (int i = 0; i < NCELL; i++) begin
      unfit[i] = CW'(i + 1) > cell_cnt;
      ev_m[i]  = (i % 2) == 1;
      od_m[i]  = (i % 2) == 0;
    end
  end

  AST_MEAS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    meas_win |-> (shunt_en == '0));                                       // R4
  AST_UNFIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (shunt_en & unfit) == '0);                                            // R8
  AST_ONE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(shunt_en & ev_m)) && (|(shunt_en & od_m))));                     // R5
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (shunt_en == '0 && !meas_win));                               // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !meas_win && !$past(meas_win) && $stable(cell_cnt))
      |-> $stable(shunt_en));                                             // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(en)) |=> meas_win);                                     // R10
endmodule

bind cell_bal_seq cell_bal_seq_chk #(.NCELL(NCELL)) chk_i (
  .clk(clk), .rst_n(rst_n), .cell_cnt(cell_cnt), .ofs_sel(ofs_sel),
  .src_sleep(src_sleep), .chg_det(chg_det), .sleep_pin(sleep_pin),
  .shunt_en(shunt_en), .meas_win(meas_win)
);

// File: tb/cell_bal_seq_tb.sv
module cell_bal_seq_tb_top;
  localparam int NC = 10, VW = 13;
  logic clk = 0, rst_n = 0;
  logic [NC*VW-1:0] cell_mv = '0;
  logic [3:0] cell_cnt = 4'd10, ov_sel = 0, ofs_sel = 0;
  logic src_sleep = 0, chg_det = 0, sleep_pin = 0;
  logic [NC-1:0] shunt_en;
  logic meas_win;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  localparam logic [NC-1:0] EVM = 10'b1010101010, ODM = 10'b0101010101;

  always #4 clk = ~clk;

  cell_bal_seq #(.NCELL(NC), .VW(VW), .UNIT_CLKS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cell_mv(cell_mv), .cell_cnt(cell_cnt),
    .ov_sel(ov_sel), .ofs_sel(ofs_sel), .src_sleep(src_sleep),
    .chg_det(chg_det), .sleep_pin(sleep_pin), .shunt_en(shunt_en),
    .meas_win(meas_win));

  task automatic chk(string tag, logic [NC:0] act, logic [NC:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int vbal_of(int ov, int of);
    int o = (ov > 8) ? 8 : ov, f = (of > 8) ? 8 : of, v;
    v = 4100 + 50 * o - 50 * f;
    return (v < 3750) ? 3750 : v;
  endfunction

  function automatic logic [NC*VW-1:0] mk(int vb, logic [NC-1:0] pat);
    logic [NC*VW-1:0] r;
    for (int k = 0; k < NC; k++)
      r[k*VW +: VW] = pat[k] ? VW'(vb + 1 + k) : VW'(vb - (k % 2));
    return r;
  endfunction

  function automatic logic [NC:0] expect_sh(logic [NC-1:0] pat, int cnt,
                                            logic [NC-1:0] par, bit on);
    logic [NC-1:0] use_m = NC'((1 << cnt) - 1);
    if (!on || ((pat & use_m) == use_m)) return '0;
    return {1'b0, pat & use_m & par};
  endfunction

  task automatic run_combo(int ov, int of, int cnt, logic [NC-1:0] pat);
    bit on = (of != 0);
    ov_sel = 4'(ov); ofs_sel = 4'(of); cell_cnt = 4'(cnt);
    cell_mv = mk(vbal_of(ov, of), pat);
    chg_det = 1;
    step(1);   chk("R3 meas start",   {meas_win, shunt_en}, {on, 10'b0});
    step(9);   chk("R4 meas end",     {meas_win, shunt_en}, {on, 10'b0});
    step(1);   chk("R6 even start",   {meas_win, shunt_en}, expect_sh(pat, cnt, EVM, on));
    step(245); chk("R5 even end",     {meas_win, shunt_en}, expect_sh(pat, cnt, EVM, on));
    step(1);   chk("R3 meas b",       {meas_win, shunt_en}, {on, 10'b0});
    step(10);  chk("R5 odd start",    {meas_win, shunt_en}, expect_sh(pat, cnt, ODM, on));
    step(245); chk("R8 odd end",      {meas_win, shunt_en}, expect_sh(pat, cnt, ODM, on));
    step(1);   chk("R3 wrap",         {meas_win, shunt_en}, {on, 10'b0});
    chg_det = 0;
    step(1);   chk("R2 off",          {meas_win, shunt_en}, 11'b0);
  endtask

  initial begin
    step(2);
    chk("R2 reset", {meas_win, shunt_en}, 11'b0);
    rst_n = 1;
    step(1);
    for (int ov = 0; ov <= 8; ov++)
      for (int of = 0; of <= 8; of++) begin
        int c = ov * 9 + of;
        logic [NC-1:0] pat = (c % 5 == 2) ? 10'h3FF : NC'(c * 37 + 'h155);
        run_combo(ov, of, 5 + c % 6, pat);   // R1 R7 sweep
      end
    run_combo(12, 15, 10, 10'h2C3);           // R1 index clamp
    // R2 source select: sleep pin path
    ov_sel = 4; ofs_sel = 2; cell_cnt = 10; src_sleep = 1; chg_det = 1; sleep_pin = 0;
    cell_mv = mk(vbal_of(4, 2), 10'h0F0);
    step(11); chk("R2 wrong source", {meas_win, shunt_en}, 11'b0);
    sleep_pin = 1;
    step(1);  chk("R2 sleep src", {meas_win, shunt_en}, {1'b1, 10'b0});
    step(10); chk("R6 sleep even", {meas_win, shunt_en}, expect_sh(10'h0F0, 10, EVM, 1));
    // R9 latched readings hold through the window
    step(10); cell_mv = mk(vbal_of(4, 2), 10'h00F);
    step(80); chk("R9 held", {meas_win, shunt_en}, expect_sh(10'h0F0, 10, EVM, 1));
    step(166); chk("R9 relatch odd", {meas_win, shunt_en}, expect_sh(10'h00F, 10, ODM, 1));
    // R10 disable mid window then restart
    sleep_pin = 0;
    step(1); chk("R10 drop", {meas_win, shunt_en}, 11'b0);
    sleep_pin = 1;
    step(1); chk("R10 restart meas", {meas_win, shunt_en}, {1'b1, 10'b0});
    step(10); chk("R10 even after restart", {meas_win, shunt_en}, expect_sh(10'h00F, 10, EVM, 1));
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule